// File: doc/BRIEF.md
# PRBS Manchester Test-Stream Transmitter

This block produces a self-timed Manchester line signal for link and receiver testing, working from nothing more than a fast system clock and a reset. A counter divides the system clock down to the bit rate. It yields a one-cycle strobe per bit and a square-wave bit clock of even duty. A 9-bit maximal-length feedback shift register steps once per strobe and provides the NRZ test data. The line output is the NRZ data XORed with the bit clock.

The NRZ data, the bit clock and the bit strobe are brought out next to the line signal. A downstream clock-recovery receiver and its error checker can then compare what they decode against the data that was actually sent. With the default division of 10, a 100 MHz system clock gives a 10 Mb/s stream.

Top module: `prbs_manchester_tx`

## Requirements
- R1: While reset (`rst_i`, active high, synchronous) is applied, and in the first cycle after it is released, `nrz_o` is 1, `bit_clk_o` is 0 and `bit_en_o` is 0. The generator register is seeded with all ones. The first bit period starts in the reset cycle.
- R2: `bit_en_o` is high for exactly one system clock out of every `DIV_RATIO` (default 10). That cycle is the last cycle of each bit period, phase `DIV_RATIO-1`, counting from phase 0 at the start of the period.
- R3: `bit_clk_o` is 0 for phases 0 to `DIV_RATIO/2-1` of each bit period and 1 for the remaining phases. This is a 50% duty square wave at the bit rate.
- R4: The generator register advances only on cycles where `bit_en_o` is high. `nrz_o` therefore holds one value for all `DIV_RATIO` cycles of a bit period and can change only when a new period begins.
- R5: On each advance the register state s (bits 8..0) becomes {s[7:0], s[4] XOR s[8]}. `nrz_o` is s[8].
- R6: The NRZ bit sequence repeats every 511 bits. It contains 256 ones in each period, and the register never holds all zeros.
- R7: `line_o` equals `nrz_o` XOR `bit_clk_o` in every cycle. A data 1 is therefore sent high then low, and a data 0 low then high.
- R8: A reset applied in the middle of a bit period discards the current phase and sequence position. After release, the stream restarts from the seed and from phase 0, exactly as after the first reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| line_o | output | 1 | Manchester-coded line signal |
| nrz_o | output | 1 | Pseudo-random NRZ data bit being sent |
| bit_clk_o | output | 1 | Bit-rate square wave, low in the first half of each bit |
| bit_en_o | output | 1 | One-cycle strobe in the last cycle of each bit period |

## Verification
A miscounted divider shows up at once: within one bit period, `bit_en_o` appears in the wrong phase or `bit_clk_o` changes level at the wrong cycle. A wrong feedback tap or shift direction can leave the first nine bits unchanged, because they come from the seed. It does, however, produce a wrong NRZ bit within about ten bit periods, and this spoils both the period-511 repeat and the count of 256 ones. A bad seed or a reset that does not clear the divider shows up in the first cycle after release, and again after the mid-period reset.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

    localparam int unsigned DEF_DIV_RATIO = 10;
    localparam int unsigned DEF_PRBS_W    = 9;
    localparam int unsigned DEF_TAP_LO    = 4;
    localparam int unsigned DEF_TAP_HI    = 8;

    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } half_e;

endpackage

// File: rtl/mtx_bitdiv.sv
module mtx_bitdiv
    import mtx_pkg::*;
#(
    parameter int unsigned DIV_RATIO = DEF_DIV_RATIO
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic bit_en_o,
    output logic bit_clk_o
);

    localparam int unsigned CNT_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
    localparam int unsigned HALF  = DIV_RATIO / 2;
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(DIV_RATIO - 1);
    localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        half_e            half;
        logic             en;
    } div_t;

    div_t div_d, div_q;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        cnt_nx      = (div_q.cnt == LAST) ? '0 : div_q.cnt + 1'b1;
        div_d.cnt   = cnt_nx;
        div_d.en    = (cnt_nx == LAST);
        div_d.half  = (cnt_nx >= HALF_C) ? HALF_HIGH : HALF_LOW;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            div_q <= '{cnt: '0, half: HALF_LOW, en: 1'b0};
        end else begin
            div_q <= div_d;
        end
    end

    assign bit_en_o  = div_q.en;
    assign bit_clk_o = (div_q.half == HALF_HIGH);

    // R2: the strobe never lasts more than one cycle
    a_r2_strobe_single: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_en_o |=> !bit_en_o);

    // R3: the strobe falls in the high half, and the next bit opens low
    a_r3_strobe_in_high: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_en_o |-> bit_clk_o);
    a_r3_new_bit_low: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_en_o |=> !bit_clk_o);

endmodule

// File: rtl/mtx_prbs.sv
module mtx_prbs
    import mtx_pkg::*;
#(
    parameter int unsigned PRBS_W = DEF_PRBS_W,
    parameter int unsigned TAP_LO = DEF_TAP_LO,
    parameter int unsigned TAP_HI = DEF_TAP_HI
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic step_i,
    output logic nrz_o
);

    localparam logic [PRBS_W-1:0] SEED = '1;

    typedef struct packed {
        logic [PRBS_W-1:0] sr;
    } prbs_t;

    prbs_t prbs_d, prbs_q;
    logic  fb;

    always_comb begin
        fb     = prbs_q.sr[TAP_LO] ^ prbs_q.sr[TAP_HI];
        prbs_d = prbs_q;
        if (step_i) begin
            prbs_d.sr = {prbs_q.sr[PRBS_W-2:0], fb};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prbs_q.sr <= SEED;
        end else begin
            prbs_q <= prbs_d;
        end
    end

    assign nrz_o = prbs_q.sr[PRBS_W-1];

    // R4: no step pulse, no movement
    a_r4_hold_without_step: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_i |=> $stable(prbs_q.sr));

    // R6: the all-zero lock-up state is never reached
    a_r6_never_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        prbs_q.sr != '0);

endmodule

// File: rtl/mtx_line_enc.sv
module mtx_line_enc (
    input  logic nrz_i,
    input  logic bit_clk_i,
    output logic line_o
);

    always_comb begin
        line_o = nrz_i ^ bit_clk_i;
    end

endmodule

// File: rtl/prbs_manchester_tx.sv
module prbs_manchester_tx
    import mtx_pkg::*;
#(
    parameter int unsigned DIV_RATIO = DEF_DIV_RATIO,
    parameter int unsigned PRBS_W    = DEF_PRBS_W,
    parameter int unsigned TAP_LO    = DEF_TAP_LO,
    parameter int unsigned TAP_HI    = DEF_TAP_HI
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic line_o,
    output logic nrz_o,
    output logic bit_clk_o,
    output logic bit_en_o
);

    logic strobe;
    logic sq_clk;
    logic data;

    mtx_bitdiv #(
        .DIV_RATIO (DIV_RATIO)
    ) u_div (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .bit_en_o  (strobe),
        .bit_clk_o (sq_clk)
    );

    mtx_prbs #(
        .PRBS_W (PRBS_W),
        .TAP_LO (TAP_LO),
        .TAP_HI (TAP_HI)
    ) u_prbs (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .step_i (strobe),
        .nrz_o  (data)
    );

    mtx_line_enc u_enc (
        .nrz_i     (data),
        .bit_clk_i (sq_clk),
        .line_o    (line_o)
    );

    assign nrz_o     = data;
    assign bit_clk_o = sq_clk;
    assign bit_en_o  = strobe;

    // R4: data changes only at a bit boundary
    a_r4_nrz_held: assert property (@(posedge clk_i) disable iff (rst_i)
        !bit_en_o |=> $stable(nrz_o));

    // R7: each bit carries a mid-period transition of the line
    a_r7_mid_transition: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(bit_clk_o) |-> (line_o != $past(line_o)));

endmodule

// File: tb/prbs_manchester_tx_tb.sv
module prbs_manchester_tx_tb_top;

    localparam int DIV  = 10;
    localparam int HALF = DIV / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line, nrz, bclk, ben;

    always #4 clk = ~clk;

    prbs_manchester_tx dut_i (
        .clk_i     (clk),
        .rst_i     (rst),
        .line_o    (line),
        .nrz_o     (nrz),
        .bit_clk_o (bclk),
        .bit_en_o  (ben)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    exp_q[$];
    logic  rst_at_edge = 1'b1;
    logic  hist [0:639];
    int    bit_idx = 0;
    bit    record = 1'b0;
    int    phase = 0;
    bit    pend = 1'b0;
    bit    cur = 1'b0;
    string rst_tag = "R1";

    always @(posedge clk) rst_at_edge <= rst;

    task automatic chk(string req, string what, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic chk_int(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: expected NRZ bits from the R5 recurrence, seed per R1
    task automatic load_expected(int nbits);
        bit [8:0] s = '1;
        exp_q.delete();
        for (int i = 0; i < nbits; i++) begin
            exp_q.push_back(s[8]);
            s = {s[7:0], s[4] ^ s[8]};
        end
    endtask

    task automatic do_reset(int nbits);
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 load_expected(nbits);
        @(posedge clk);
        @(posedge clk); #1 rst = 1'b0;
    endtask

    // Monitor: scoreboard of one entry per bit, checked every cycle
    always @(negedge clk) begin
        if (rst_at_edge) begin
            chk(rst_tag, "reset nrz", nrz, 1'b1);
            chk(rst_tag, "reset bit_clk", bclk, 1'b0);
            chk(rst_tag, "reset bit_en", ben, 1'b0);
            phase   = 1;
            pend    = 1'b1;
            bit_idx = 0;
        end else begin
            if (pend || phase == 0) begin
                pend = 1'b0;
                if (exp_q.size() == 0) begin
                    n_vec++; n_bad++;
                    $display("FAIL R4 scoreboard empty actual=0 expected=1");
                    cur = 1'b0;
                end else begin
                    cur = exp_q.pop_front();
                end
                if (record && bit_idx < 640) hist[bit_idx] = nrz;
                bit_idx++;
            end
            chk("R4,R5", "nrz", nrz, cur);
            chk("R3", "bit_clk", bclk, logic'(phase >= HALF));
            chk("R2", "bit_en", ben, logic'(phase == DIV - 1));
            chk("R7", "line", line, cur ^ logic'(phase >= HALF));
            phase = (phase + 1) % DIV;
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int ones;
        load_expected(540);
        record = 1'b1;
        do_reset(540);
        repeat (5304) @(posedge clk);
        record  = 1'b0;
        // R8: reset in the middle of a bit period
        rst_tag = "R8";
        do_reset(70);
        repeat (650) @(posedge clk);
        #2;
        // R6: repeat period and balance of the sequence
        for (int k = 0; k < 15; k++) begin
            chk("R6", "period 511 repeat", hist[511 + k], hist[k]);
        end
        ones = 0;
        for (int k = 0; k < 511; k++) begin
            if (hist[k] === 1'b1) ones++;
        end
        chk_int("R6", "ones per period", ones, 256);
        finish_run();
    end

endmodule